// File: doc/BRIEF.md
# External Slave Sync Reset Aligner

This block keeps a pixel counter and a line counter aligned to horizontal and vertical reset pulses supplied from outside the chip. Each pulse input has a sense input that picks its active level. The block acts only on the transition from inactive to active. A horizontal reset reloads the pixel counter. A mode input selects the value loaded: the first active-video pixel, or the first pixel of horizontal blanking.

A vertical reset counts only when it arrives close to a horizontal reset. Its active edge must fall within a parameterised number of clocks of a horizontal reset edge, either before or after it. A qualified vertical reset loads the line counter with line 4, the first line of the odd field, and sets a sticky `locked` output. A vertical reset outside that window is dropped. Between reset pulses both counters run freely, so timing continues through missing pulses. An odd-field flag is derived from the line counter. All outputs are registered.

Top module: `ext_sync_aligner`

## Requirements
- R1: While `rst` is high, and after it falls until the next rising clock edge: `pix_cnt` = 0, `line_cnt` = 1, `odd_field` = 0 and `locked` = 0.
- R2: With no reset pulses, `pix_cnt` rises by one each clock and wraps from PIX_PER_LINE-1 to 0. At that wrap `line_cnt` rises by one. `line_cnt` counts lines from 1, and it wraps from LINES_PER_FRAME to 1.
- R3: A pulse input is active when its level equals its sense input. Sense 1 means the rising edge acts. Sense 0 means the falling edge acts, and a rising edge then does nothing.
- R4: The input is sampled on rising clock edges. After the second rising edge, counting from the first one that samples an active horizontal level, `pix_cnt` equals ACT_START if `hreset_mode` = 1, or BLK_START if `hreset_mode` = 0. Counting then resumes from that value.
- R5: A horizontal input held active causes only one load. An input that is already at its active level when reset is released causes no load until it has been inactive and then becomes active again.
- R6: Let h and v be the clocks in which the horizontal and vertical active edges are detected. If |v - h| <= WIN, the vertical reset is accepted. After the same two-edge latency, measured from the later of the two pulses, `line_cnt` = VRESET_LINE (4) and `locked` = 1.
- R7: A vertical edge with no horizontal edge within WIN clocks on either side leaves `line_cnt` and `locked` unchanged.
- R8: `locked` stays 1 from the first accepted vertical reset until `rst`.
- R9: `odd_field` is 1 exactly while VRESET_LINE <= `line_cnt` < EVEN_LINE.
- R10: A horizontal load never changes `line_cnt`. Only the natural pixel wrap advances the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | External horizontal reset pulse |
| vsync_in | input | 1 | External vertical reset pulse |
| hsync_sense | input | 1 | Active level of `hsync_in` |
| vsync_sense | input | 1 | Active level of `vsync_in` |
| hreset_mode | input | 1 | 1: horizontal edge marks active-video start; 0: blanking start |
| pix_cnt | output | $clog2(PIX_PER_LINE) | Pixel position in the line |
| line_cnt | output | $clog2(LINES_PER_FRAME+1) | Line number, counted from 1 |
| odd_field | output | 1 | High while the line is in the odd field |
| locked | output | 1 | Set by an accepted vertical reset |

## Verification
The hardest cases to reach are the two ends of the coincidence window. These are a vertical edge exactly WIN clocks from a horizontal edge, and one exactly WIN+1 clocks away, in both orders. The bench reaches them by driving the two pulses from a known reset point with exact negedge offsets of ±4, ±5 and 0. Because each case starts from a known reset point, an accepted pulse gives line 4 and a rejected one leaves line 1. Field and frame wraps are reached by letting the counters run freely over a reduced frame.

// File: rtl/esa_pkg.sv
package esa_pkg;
  typedef enum logic {HLOAD_BLANK = 1'b0, HLOAD_ACTIVE = 1'b1} hload_e;

  function automatic logic in_span(input int v, input int lo, input int hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/esa_edge_track.sv
module esa_edge_track #(
  parameter int WIN = 4,
  localparam int AGE_W = $clog2(WIN + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic sense,
  input  logic clr,
  output logic edge_o,
  output logic recent_o
);
  logic             lvl_q, lvl_d;
  logic             valid_q;
  logic [AGE_W-1:0] age_q;

  // Sampled level normalised to "active"; reset as active so no false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      lvl_d <= 1'b1;
    end else begin
      lvl_q <= (pin == sense);
      lvl_d <= lvl_q;
    end
  end

  assign edge_o = lvl_q & ~lvl_d;

  // Distance in clocks since the last unconsumed edge, saturating past WIN.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      age_q   <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
    end else if (edge_o) begin
      valid_q <= 1'b1;
      age_q   <= AGE_W'(1);
    end else if (valid_q && (age_q <= AGE_W'(WIN))) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign recent_o = valid_q && (age_q <= AGE_W'(WIN));

  // R5
  edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/esa_timebase.sv
module esa_timebase #(
  parameter int PIX_PER_LINE    = 858,
  parameter int LINES_PER_FRAME = 525,
  parameter int ACT_START       = 122,
  parameter int BLK_START       = 842,
  parameter int VRESET_LINE     = 4,
  parameter int EVEN_LINE       = 266,
  localparam int PIX_W  = $clog2(PIX_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_load,
  input  esa_pkg::hload_e   h_mode,
  input  logic              v_load,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q,
  output logic              odd_q
);
  logic [PIX_W-1:0]  pix_n;
  logic [LINE_W-1:0] line_n;
  logic              pix_wrap;

  always_comb begin
    pix_wrap = (pix_q == PIX_W'(PIX_PER_LINE - 1));
    if (h_load)
      pix_n = (h_mode == esa_pkg::HLOAD_ACTIVE) ? PIX_W'(ACT_START) : PIX_W'(BLK_START);
    else if (pix_wrap)
      pix_n = '0;
    else
      pix_n = pix_q + 1'b1;

    if (v_load)
      line_n = LINE_W'(VRESET_LINE);
    else if (!h_load && pix_wrap)
      line_n = (line_q == LINE_W'(LINES_PER_FRAME)) ? LINE_W'(1) : line_q + 1'b1;
    else
      line_n = line_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      line_q <= LINE_W'(1);
      odd_q  <= 1'b0;
    end else begin
      pix_q  <= pix_n;
      line_q <= line_n;
      odd_q  <= esa_pkg::in_span(int'(line_n), VRESET_LINE, EVEN_LINE);
    end
  end

  // R2
  pix_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pix_q) < PIX_PER_LINE);
  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    (line_q >= LINE_W'(1)) && (int'(line_q) <= LINES_PER_FRAME));
  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!h_load && !pix_wrap) |=> (pix_q == $past(pix_q) + 1'b1));
  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_load && !v_load) |=> $stable(line_q));
endmodule

// File: rtl/ext_sync_aligner.sv
module ext_sync_aligner #(
  parameter int PIX_PER_LINE    = 858,
  parameter int LINES_PER_FRAME = 525,
  parameter int ACT_START       = 122,
  parameter int BLK_START       = 842,
  parameter int VRESET_LINE     = 4,
  parameter int EVEN_LINE       = 266,
  parameter int WIN             = 4,
  localparam int PIX_W  = $clog2(PIX_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              hsync_sense,
  input  logic              vsync_sense,
  input  logic              hreset_mode,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              odd_field,
  output logic              locked
);
  logic h_edge, h_recent, v_edge, v_recent, accept;

  esa_edge_track #(.WIN(WIN)) h_trk_i (
    .clk(clk), .rst(rst), .pin(hsync_in), .sense(hsync_sense),
    .clr(accept), .edge_o(h_edge), .recent_o(h_recent));

  esa_edge_track #(.WIN(WIN)) v_trk_i (
    .clk(clk), .rst(rst), .pin(vsync_in), .sense(vsync_sense),
    .clr(accept), .edge_o(v_edge), .recent_o(v_recent));

  // Coincidence in either order; both pending edges are consumed on accept.
  assign accept = (v_edge && (h_edge || h_recent)) || (h_edge && v_recent);

  esa_timebase #(
    .PIX_PER_LINE(PIX_PER_LINE), .LINES_PER_FRAME(LINES_PER_FRAME),
    .ACT_START(ACT_START), .BLK_START(BLK_START),
    .VRESET_LINE(VRESET_LINE), .EVEN_LINE(EVEN_LINE)
  ) tb_i (
    .clk(clk), .rst(rst), .h_load(h_edge),
    .h_mode(esa_pkg::hload_e'(hreset_mode)), .v_load(accept),
    .pix_q(pix_cnt), .line_q(line_cnt), .odd_q(odd_field));

  always_ff @(posedge clk) begin
    if (rst)         locked <= 1'b0;
    else if (accept) locked <= 1'b1;
  end

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  // R6
  vload_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (line_cnt == LINE_W'(VRESET_LINE)) && locked);
  // R7
  lone_v_chk: assert property (@(posedge clk) disable iff (rst)
    (v_edge && !h_edge && !h_recent && !locked) |=> !locked);
endmodule

// File: tb/ext_sync_aligner_tb.sv
module ext_sync_aligner_tb_top;
  localparam int PIX = 20, LINES = 12, ACT = 5, BLK = 17, VL = 4, EVL = 9, WIN = 4;
  localparam int PW = $clog2(PIX), LW = $clog2(LINES + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic hsync_in = 1'b0, vsync_in = 1'b0;
  logic hs_sense = 1'b1, vs_sense = 1'b1, hmode = 1'b1;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic odd_field, locked;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ext_sync_aligner #(
    .PIX_PER_LINE(PIX), .LINES_PER_FRAME(LINES), .ACT_START(ACT), .BLK_START(BLK),
    .VRESET_LINE(VL), .EVEN_LINE(EVL), .WIN(WIN)
  ) dut_i (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hsync_sense(hs_sense), .vsync_sense(vs_sense), .hreset_mode(hmode),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .odd_field(odd_field), .locked(locked));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_h(input bit act); hsync_in = act ? hs_sense : ~hs_sense; endtask
  task automatic set_v(input bit act); vsync_in = act ? vs_sense : ~vs_sense; endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit hs, input bit vs);
    @(negedge clk);
    hs_sense = hs; vs_sense = vs;
    rst = 1'b1; set_h(0); set_v(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(1, 1);
    chk("R1 pix", pix_cnt, 0);
    chk("R1 line", line_cnt, 1);
    chk("R1 odd", odd_field, 0);
    chk("R1 locked", locked, 0);
  endtask

  task automatic t_free_run;
    do_reset(1, 1);
    wait_n(7);   chk("R2 pix count", pix_cnt, 7);
    wait_n(13);  chk("R2 pix wrap", pix_cnt, 0);
                 chk("R2 line step", line_cnt, 2);
    wait_n(40);  chk("R9 line4", line_cnt, 4);
                 chk("R9 odd at line4", odd_field, 1);
    wait_n(100); chk("R9 line9", line_cnt, 9);
                 chk("R9 even at line9", odd_field, 0);
    wait_n(60);  chk("R2 last line", line_cnt, 12);
    wait_n(20);  chk("R2 frame wrap", line_cnt, 1);
  endtask

  task automatic t_hmode;
    do_reset(1, 1);
    hmode = 1'b1;
    wait_n(3);
    set_h(1);
    wait_n(2);  chk("R4 active-start load", pix_cnt, ACT);
                chk("R10 line kept", line_cnt, 1);
    wait_n(4);  chk("R5 held active no reload", pix_cnt, ACT + 4);
    set_h(0); hmode = 1'b0;
    wait_n(3);
    set_h(1);
    wait_n(2);  chk("R4 blank-start load", pix_cnt, BLK);
                chk("R10 line kept after blank load", line_cnt, 1);
    set_h(0);
  endtask

  task automatic t_polarity_low;
    do_reset(0, 0);
    hmode = 1'b1;
    wait_n(2);  chk("R3 idle high no load", pix_cnt, 2);
    set_h(1);   // drives low
    wait_n(2);  chk("R3 falling edge loads", pix_cnt, ACT);
    set_h(0);   // rising edge, inactive
    wait_n(2);  chk("R3 rising edge ignored", pix_cnt, ACT + 2);
  endtask

  task automatic t_active_at_reset;
    @(negedge clk);
    hs_sense = 1'b1; rst = 1'b1; hsync_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wait_n(4);  chk("R5 active at release no load", pix_cnt, 4);
    set_h(0);
  endtask

  // d >= 0: horizontal first, vertical d clocks later; d < 0: vertical first.
  task automatic t_window(input int d, input bit hs, input bit vs);
    int exp_line;
    string tag;
    exp_line = (d <= WIN && d >= -WIN) ? VL : 1;
    tag = (exp_line == VL) ? "R6" : "R7";
    do_reset(hs, vs);
    hmode = 1'b1;
    wait_n(2);
    if (d >= 0) begin
      set_h(1);
      repeat (d) @(negedge clk);
      set_v(1);
    end else begin
      set_v(1);
      repeat (-d) @(negedge clk);
      set_h(1);
    end
    wait_n(2);
    chk($sformatf("%s line d=%0d", tag, d), line_cnt, exp_line);
    chk($sformatf("%s locked d=%0d", tag, d), locked, exp_line == VL ? 1 : 0);
    set_h(0); set_v(0);
  endtask

  task automatic t_lock_hold;
    t_window(0, 1, 1);
    wait_n(30); chk("R8 locked held", locked, 1);
    do_reset(1, 1);
    chk("R8 cleared by rst", locked, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_free_run();
    t_hmode();
    t_polarity_low();
    t_active_at_reset();
    t_window(0, 1, 1);
    t_window(4, 1, 1);
    t_window(5, 1, 1);
    t_window(-4, 1, 1);
    t_window(-5, 1, 1);
    t_window(2, 0, 0);
    t_lock_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule